// File: doc/BRIEF.md
# Link acknowledgement-ID recovery controller

This block holds the acknowledgement-ID state of one serial packet link and lets software repair it after a stall or a hot swap. It tracks three 5-bit IDs that wrap modulo 32:
- the ID expected on the next received packet;
- the ID that the next new transmitted packet will carry;
- the oldest transmitted packet that is still unacknowledged.

The sent-but-unacknowledged IDs form a contiguous window from the oldest ID up to the next outbound ID, holding at most `DEPTH` entries.

Software reaches the state through a small register port with one address for both read and write. Writes to the ID registers act according to what is outstanding at that moment. A write may:
- rebase the retransmission of outstanding packets;
- acknowledge the older part of the window in one step;
- be ignored;
- raise an error flag and leave the state untouched.

A link-maintenance register sends commands to the symbol transmitter through a valid/ready request interface. A reset command holds back transmission, sends a burst of reset link-requests, and then waits in an output-error state until a link response arrives. That response is captured in a read-only register.

Top module: `ackid_recovery_ctrl`

Register map (`reg_addr`):

| Address | Register | Access and content |
|---|---|---|
| 0 | control | write-only; bit 0 = clear outstanding |
| 1 | inbound ID | read/write |
| 2 | outbound ID | read/write |
| 3 | oldest ID | read/write |
| 4 | link-maintenance command | read/write; bits [2:0] |
| 5 | link response | read-only |
| 6 | status | see R9 |

Read data is registered: `reg_rdata` shows the register selected by `reg_addr` one cycle later.

## Requirements
- R1: After synchronous reset all three IDs read 0, status reads 0, and `sym_req_valid`, `tx_stop`, `out_err`, `retx_valid` and `rx_accept` are low.
- R2: Writing 1 to bit 0 of the control register at address 0 empties the window: the outstanding count becomes 0 and the oldest ID takes the value of the next outbound ID.
- R3: A write to the inbound ID register at address 1 sets the expected ID and leaves the stopped state. A packet presented in the same cycle is dropped, so `rx_accept` stays low.
- R4: A received packet whose ID equals the expected ID gives a one-cycle `rx_accept` one cycle later and advances the expected ID modulo 32. A packet with any other ID puts the receiver into the stopped state (status bit 1). Packets that arrive while stopped are dropped without changing the expected ID.
- R5: A write to the outbound ID register at address 2 while nothing is outstanding sets both the next outbound ID and the oldest ID to the written value.
- R6: A write to the outbound ID while N packets are outstanding gives a one-cycle `retx_valid` one cycle later, with `retx_base` equal to the written value and `retx_count` equal to N. The oldest ID becomes the written value and the next outbound ID becomes (written value + N) mod 32.
- R7: A write to the oldest ID register at address 3 while nothing is outstanding changes nothing.
- R8: A write to the oldest ID with a value at offset k from the oldest ID, where k is no larger than the outstanding count, acknowledges k entries. The oldest ID becomes the written value and the next outbound ID is unchanged.
- R9: A write to the oldest ID with a value outside the window sets the error flag and changes no ID and no count. The status register at address 6 holds:
  - bit 0: error flag, cleared by writing 1 to it;
  - bit 1: receiver stopped;
  - bit 2: output-error state;
  - bits [15:8]: outstanding count.
- R10: Writing command 0b011 to address 4 raises `tx_stop` and then issues exactly `RST_REQS` (4) requests with `sym_req_cmd` = 0b011. Each request is held until `sym_req_ready`. The block then stays in the output-error state (`out_err`) until `lresp_valid`, after which `tx_stop` and `out_err` fall.
- R11: Command 0b100 issues a single request with `sym_req_cmd` = 0b100. Any other command code issues no request. Reading address 4 returns the last command written.
- R12: The value on `lresp_data` when `lresp_valid` is high is captured and reads back from address 5.
- R13: `tx_pkt_sent` advances the next outbound ID and adds one to the outstanding count, but not when the count has reached `DEPTH` (8). `tx_ack` retires the oldest entry when one is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for `reg_addr` |
| tx_pkt_sent | input | 1 | A new packet was sent with `tx_next_id` |
| tx_ack | input | 1 | The oldest outstanding packet was accepted |
| tx_next_id | output | 5 | ID for the next new packet |
| retx_valid | output | 1 | Retransmit rebase pulse |
| retx_base | output | 5 | First ID of the retransmission |
| retx_count | output | 4 | Number of packets to retransmit |
| rx_pkt_valid | input | 1 | Received packet present |
| rx_pkt_id | input | 5 | ID of the received packet |
| rx_accept | output | 1 | Received packet accepted |
| lresp_valid | input | 1 | Link response received |
| lresp_data | input | 16 | Link response contents |
| sym_req_valid | output | 1 | Link-request to the symbol transmitter |
| sym_req_cmd | output | 3 | Command code of the request |
| sym_req_ready | input | 1 | Transmitter takes the request |
| tx_stop | output | 1 | Pending transmission held back |
| out_err | output | 1 | Waiting for a link response |
| ackid_err | output | 1 | Out-of-window write recorded |

## Verification
The window assertions assume that the transmitter stops reporting sent packets while `tx_stop` is high. They also assume that the sent and acknowledge strobes never share a cycle with a register write to addresses 0, 2 or 3; in such a cycle the write wins and the strobes are ignored. The stimulus therefore issues every register write on its own, with the strobes low. The request-hold assertion relies on `sym_req_ready` being a plain level, sampled at the clock edge and not fed back from `sym_req_valid` in the same cycle; the bench drives it from its own tasks. Link responses are sent only after the reset request burst has finished, so the output-error wait is always entered before it is released.

// File: rtl/ackid_pkg.sv
package ackid_pkg;
  localparam logic [2:0] A_CTRL  = 3'd0;
  localparam logic [2:0] A_INB   = 3'd1;
  localparam logic [2:0] A_OUTB  = 3'd2;
  localparam logic [2:0] A_OLD   = 3'd3;
  localparam logic [2:0] A_MAINT = 3'd4;
  localparam logic [2:0] A_LRESP = 3'd5;
  localparam logic [2:0] A_STAT  = 3'd6;

  localparam logic [2:0] CMD_RESET  = 3'b011;
  localparam logic [2:0] CMD_INSTAT = 3'b100;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_FLUSH, SQ_SEND, SQ_WAIT, SQ_STAT
  } seq_state_e;
endpackage

// File: rtl/ackid_tx_window.sv
module ackid_tx_window #(
  parameter int ID_W  = 5,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            out_wr,
  input  logic            old_wr,
  input  logic            err_clr,
  input  logic [ID_W-1:0] wdata,
  input  logic            send,
  input  logic            ack,
  output logic [ID_W-1:0] next_id,
  output logic [ID_W-1:0] old_id,
  output logic [CW-1:0]   cnt,
  output logic            err,
  output logic            retx_valid,
  output logic [ID_W-1:0] retx_base,
  output logic [CW-1:0]   retx_count
);
  logic [ID_W-1:0] offs;
  logic            in_win, do_send, do_ack;

  assign offs    = wdata - old_id;
  assign in_win  = ((ID_W+1)'(offs)) <= ((ID_W+1)'(cnt));
  assign do_send = send && (cnt != CW'(DEPTH));
  assign do_ack  = ack && (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_id    <= '0;
      old_id     <= '0;
      cnt        <= '0;
      err        <= 1'b0;
      retx_valid <= 1'b0;
      retx_base  <= '0;
      retx_count <= '0;
    end else begin
      retx_valid <= 1'b0;
      if (err_clr) err <= 1'b0;
      if (clr) begin
        old_id <= next_id;
        cnt    <= '0;
      end else if (out_wr) begin
        old_id <= wdata;
        if (cnt == '0) begin
          next_id <= wdata;
        end else begin
          next_id    <= wdata + ID_W'(cnt);
          retx_valid <= 1'b1;
          retx_base  <= wdata;
          retx_count <= cnt;
        end
      end else if (old_wr) begin
        if (cnt != '0) begin
          if (in_win) begin
            old_id <= wdata;
            cnt    <= cnt - CW'(offs);
          end else begin
            err <= 1'b1;
          end
        end
      end else begin
        if (do_send) next_id <= next_id + 1'b1;
        if (do_ack)  old_id  <= old_id + 1'b1;
        case ({do_send, do_ack})
          2'b10:   cnt <= cnt + 1'b1;
          2'b01:   cnt <= cnt - 1'b1;
          default: cnt <= cnt;
        endcase
      end
    end
  end

  assert_cnt_bound_R13: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_chain_R8: assert property (@(posedge clk) disable iff (rst)
    next_id == old_id + ID_W'(cnt));
  assert_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  assert_no_change_R9: assert property (@(posedge clk) disable iff (rst)
    (old_wr && !clr && !out_wr && cnt != '0 && !in_win) |=>
      ($stable(old_id) && $stable(cnt) && $stable(next_id) && err));
  assert_empty_old_R7: assert property (@(posedge clk) disable iff (rst)
    (old_wr && !clr && !out_wr && cnt == '0) |=> ($stable(old_id) && $stable(next_id)));
endmodule

// File: rtl/ackid_rx_track.sv
module ackid_rx_track #(
  parameter int ID_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            inb_wr,
  input  logic [ID_W-1:0] wdata,
  input  logic            rx_valid,
  input  logic [ID_W-1:0] rx_id,
  output logic [ID_W-1:0] exp_id,
  output logic            stopped,
  output logic            rx_accept
);
  always_ff @(posedge clk) begin
    if (rst) begin
      exp_id    <= '0;
      stopped   <= 1'b0;
      rx_accept <= 1'b0;
    end else begin
      rx_accept <= 1'b0;
      if (inb_wr) begin
        exp_id  <= wdata;
        stopped <= 1'b0;
      end else if (rx_valid && !stopped) begin
        if (rx_id == exp_id) begin
          exp_id    <= exp_id + 1'b1;
          rx_accept <= 1'b1;
        end else begin
          stopped <= 1'b1;
        end
      end
    end
  end

  assert_wr_drops_R3: assert property (@(posedge clk) disable iff (rst)
    inb_wr |=> (!rx_accept && !stopped));
  assert_stopped_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (stopped && !inb_wr) |=> (!rx_accept && $stable(exp_id)));
endmodule

// File: rtl/ackid_linkreq_seq.sv
module ackid_linkreq_seq
  import ackid_pkg::*;
#(
  parameter int RST_REQS = 4,
  localparam int SW      = $clog2(RST_REQS + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cmd_wr,
  input  logic [2:0] cmd,
  input  logic       req_ready,
  input  logic       lresp_valid,
  output logic       req_valid,
  output logic [2:0] req_cmd,
  output logic       tx_stop,
  output logic       out_err
);
  seq_state_e    state;
  logic [SW-1:0] sent;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      sent      <= '0;
      req_valid <= 1'b0;
      req_cmd   <= '0;
    end else begin
      case (state)
        SQ_IDLE: if (cmd_wr) begin
          if (cmd == CMD_RESET) begin
            state <= SQ_FLUSH;
          end else if (cmd == CMD_INSTAT) begin
            state     <= SQ_STAT;
            req_valid <= 1'b1;
            req_cmd   <= CMD_INSTAT;
          end
        end
        SQ_FLUSH: begin
          state     <= SQ_SEND;
          sent      <= '0;
          req_valid <= 1'b1;
          req_cmd   <= CMD_RESET;
        end
        SQ_SEND: if (req_ready) begin
          if (sent == SW'(RST_REQS - 1)) begin
            req_valid <= 1'b0;
            state     <= SQ_WAIT;
          end else begin
            sent <= sent + 1'b1;
          end
        end
        SQ_WAIT: if (lresp_valid) state <= SQ_IDLE;
        SQ_STAT: if (req_ready) begin
          req_valid <= 1'b0;
          state     <= SQ_IDLE;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign tx_stop = (state == SQ_FLUSH) || (state == SQ_SEND) || (state == SQ_WAIT);
  assign out_err = (state == SQ_WAIT);

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_cmd)));
  assert_burst_bound_R10: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_SEND) |-> (sent < SW'(RST_REQS)));
  assert_wait_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (out_err && !lresp_valid) |=> out_err);
  assert_ignored_cmd_R11: assert property (@(posedge clk) disable iff (rst)
    (state == SQ_IDLE && cmd_wr && cmd != CMD_RESET && cmd != CMD_INSTAT) |=>
      (!req_valid && !tx_stop));
endmodule

// File: rtl/ackid_recovery_ctrl.sv
module ackid_recovery_ctrl
  import ackid_pkg::*;
#(
  parameter int ID_W     = 5,
  parameter int DEPTH    = 8,
  parameter int RST_REQS = 4,
  parameter int LR_W     = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         reg_wr,
  input  logic [2:0]                   reg_addr,
  input  logic [31:0]                  reg_wdata,
  output logic [31:0]                  reg_rdata,
  input  logic                         tx_pkt_sent,
  input  logic                         tx_ack,
  output logic [ID_W-1:0]              tx_next_id,
  output logic                         retx_valid,
  output logic [ID_W-1:0]              retx_base,
  output logic [$clog2(DEPTH+1)-1:0]   retx_count,
  input  logic                         rx_pkt_valid,
  input  logic [ID_W-1:0]              rx_pkt_id,
  output logic                         rx_accept,
  input  logic                         lresp_valid,
  input  logic [LR_W-1:0]              lresp_data,
  output logic                         sym_req_valid,
  output logic [2:0]                   sym_req_cmd,
  input  logic                         sym_req_ready,
  output logic                         tx_stop,
  output logic                         out_err,
  output logic                         ackid_err
);
  localparam int CW = $clog2(DEPTH + 1);

  logic            wr_clr, wr_inb, wr_outb, wr_old, wr_maint, wr_errclr;
  logic [ID_W-1:0] wid, old_id, exp_id;
  logic [CW-1:0]   cnt;
  logic            stopped;
  logic [2:0]      last_cmd;
  logic [LR_W-1:0] lresp_q;
  logic            unused_wbits;

  assign wid          = reg_wdata[ID_W-1:0];
  assign unused_wbits = ^reg_wdata[31:ID_W];
  assign wr_clr    = reg_wr && (reg_addr == A_CTRL) && reg_wdata[0];
  assign wr_inb    = reg_wr && (reg_addr == A_INB);
  assign wr_outb   = reg_wr && (reg_addr == A_OUTB);
  assign wr_old    = reg_wr && (reg_addr == A_OLD);
  assign wr_maint  = reg_wr && (reg_addr == A_MAINT);
  assign wr_errclr = reg_wr && (reg_addr == A_STAT) && reg_wdata[0];

  ackid_tx_window #(.ID_W(ID_W), .DEPTH(DEPTH)) u_win (
    .clk, .rst, .clr(wr_clr), .out_wr(wr_outb), .old_wr(wr_old), .err_clr(wr_errclr),
    .wdata(wid), .send(tx_pkt_sent), .ack(tx_ack), .next_id(tx_next_id), .old_id(old_id),
    .cnt(cnt), .err(ackid_err), .retx_valid(retx_valid), .retx_base(retx_base),
    .retx_count(retx_count)
  );

  ackid_rx_track #(.ID_W(ID_W)) u_rx (
    .clk, .rst, .inb_wr(wr_inb), .wdata(wid), .rx_valid(rx_pkt_valid), .rx_id(rx_pkt_id),
    .exp_id(exp_id), .stopped(stopped), .rx_accept(rx_accept)
  );

  ackid_linkreq_seq #(.RST_REQS(RST_REQS)) u_seq (
    .clk, .rst, .cmd_wr(wr_maint), .cmd(reg_wdata[2:0]), .req_ready(sym_req_ready),
    .lresp_valid(lresp_valid), .req_valid(sym_req_valid), .req_cmd(sym_req_cmd),
    .tx_stop(tx_stop), .out_err(out_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      last_cmd  <= '0;
      lresp_q   <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_maint)    last_cmd <= reg_wdata[2:0];
      if (lresp_valid) lresp_q  <= lresp_data;
      case (reg_addr)
        A_INB:   reg_rdata <= 32'(exp_id);
        A_OUTB:  reg_rdata <= 32'(tx_next_id);
        A_OLD:   reg_rdata <= 32'(old_id);
        A_MAINT: reg_rdata <= 32'(last_cmd);
        A_LRESP: reg_rdata <= 32'(lresp_q);
        A_STAT:  reg_rdata <= {16'd0, 8'(cnt), 5'd0, out_err, stopped, ackid_err};
        default: reg_rdata <= '0;
      endcase
    end
  end

  assert_lresp_capture_R12: assert property (@(posedge clk) disable iff (rst)
    lresp_valid |=> (lresp_q == $past(lresp_data)));
  assert_maint_echo_R11: assert property (@(posedge clk) disable iff (rst)
    wr_maint |=> (last_cmd == $past(reg_wdata[2:0])));
endmodule

// File: tb/tb_ackid_recovery_ctrl.sv
module tb_ackid_recovery_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {wr, waddr, wdata, raddr, expected}
  localparam logic [70:0] TBL [NV] = '{
    {1'b1, 3'd1, 32'd5,  3'd1, 32'd5},   // R3 inbound write
    {1'b1, 3'd2, 32'd9,  3'd2, 32'd9},   // R5 outbound write, empty window
    {1'b0, 3'd0, 32'd0,  3'd3, 32'd9},   // R5 oldest tracks outbound
    {1'b1, 3'd3, 32'd20, 3'd3, 32'd9},   // R7 oldest write ignored
    {1'b0, 3'd0, 32'd0,  3'd2, 32'd9},   // R7 outbound untouched
    {1'b0, 3'd0, 32'd0,  3'd6, 32'd0},   // R7 no error flag
    {1'b1, 3'd4, 32'd2,  3'd4, 32'd2},   // R11 unknown command echoed
    {1'b1, 3'd1, 32'd31, 3'd1, 32'd31}   // R3 inbound write at top value
  };
  localparam int TREQ [NV] = '{3, 5, 5, 7, 7, 7, 11, 3};

  logic clk = 0, rst = 1;
  logic reg_wr = 0; logic [2:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic tx_pkt_sent = 0, tx_ack = 0;
  logic [4:0] tx_next_id, retx_base;
  logic retx_valid; logic [3:0] retx_count;
  logic rx_pkt_valid = 0; logic [4:0] rx_pkt_id = 0; logic rx_accept;
  logic lresp_valid = 0; logic [15:0] lresp_data = 0;
  logic sym_req_valid; logic [2:0] sym_req_cmd; logic sym_req_ready = 0;
  logic tx_stop, out_err, ackid_err;
  int checks = 0, errors = 0;
  int n_rst = 0, n_stat = 0, n_other = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ackid_recovery_ctrl dut (.*);

  always @(posedge clk)
    if (!rst && sym_req_valid && sym_req_ready) begin
      if (sym_req_cmd == 3'b011) n_rst++;
      else if (sym_req_cmd == 3'b100) n_stat++;
      else n_other++;
    end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string req);
    reg_addr = a;
    @(negedge clk);
    chk(req, reg_rdata, exp);
  endtask

  task automatic send(input int n);
    tx_pkt_sent = 1;
    repeat (n) @(negedge clk);
    tx_pkt_sent = 0;
  endtask

  task automatic rx(input logic [4:0] id, input logic exp_acc, input string req);
    rx_pkt_valid = 1; rx_pkt_id = id;
    @(negedge clk);
    rx_pkt_valid = 0;
    chk(req, 32'(rx_accept), 32'(exp_acc));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 outputs", {27'd0, sym_req_valid, tx_stop, out_err, retx_valid, rx_accept}, 32'd0);
    rd(3'd1, 0, "R1 inbound");
    rd(3'd2, 0, "R1 outbound");
    rd(3'd3, 0, "R1 oldest");
    rd(3'd6, 0, "R1 status");

    for (int i = 0; i < NV; i++) begin
      if (TBL[i][70]) wr(TBL[i][69:67], TBL[i][66:35]);
      rd(TBL[i][34:32], TBL[i][31:0], $sformatf("R%0d vector %0d", TREQ[i], i));
    end
    // R11 ignored command issued nothing
    chk("R11 no request", 32'(n_other + n_rst + n_stat) + 32'(sym_req_valid), 0);

    // R13 send three, acknowledge one
    send(3);
    rd(3'd6, 32'h300, "R13 count after sends");
    rd(3'd2, 12, "R13 next outbound");
    tx_ack = 1; @(negedge clk); tx_ack = 0;
    rd(3'd3, 10, "R13 oldest after ack");

    // R8 in-window oldest write
    wr(3'd3, 11);
    rd(3'd3, 11, "R8 oldest");
    rd(3'd2, 12, "R8 next unchanged");
    rd(3'd6, 32'h100, "R8 count");

    // R9 out-of-window write and clear of the flag
    wr(3'd3, 20);
    rd(3'd6, 32'h101, "R9 error set");
    rd(3'd3, 11, "R9 oldest unchanged");
    wr(3'd6, 1);
    rd(3'd6, 32'h100, "R9 error cleared");

    // R6 rebase with three outstanding, wrap of next ID
    send(2);
    wr(3'd2, 30);
    chk("R6 retx pulse", {22'd0, retx_valid, retx_base, retx_count}, {22'd0, 1'b1, 5'd30, 4'd3});
    @(negedge clk);
    chk("R6 retx single", 32'(retx_valid), 0);
    rd(3'd2, 1, "R6 next wraps");
    rd(3'd3, 30, "R6 oldest");
    rd(3'd6, 32'h300, "R6 count kept");

    // R2 clear outstanding
    wr(3'd0, 1);
    rd(3'd6, 0, "R2 count zero");
    rd(3'd3, 1, "R2 oldest equals next");

    // R13 window full
    send(9);
    rd(3'd6, 32'h800, "R13 count saturates");
    rd(3'd2, 9, "R13 next stops at full");
    wr(3'd0, 1);

    // R4 receive path
    rx(31, 1, "R4 in-order accept");
    rd(3'd1, 0, "R4 expected wraps");
    rx(5, 0, "R4 mismatch");
    rd(3'd6, 2, "R4 stopped");
    rx(0, 0, "R4 dropped while stopped");
    rd(3'd1, 0, "R4 expected held");

    // R3 inbound write with a packet in the same cycle
    rx_pkt_valid = 1; rx_pkt_id = 7;
    wr(3'd1, 7);
    rx_pkt_valid = 0;
    chk("R3 concurrent packet dropped", 32'(rx_accept), 0);
    rd(3'd6, 0, "R3 stopped cleared");
    rd(3'd1, 7, "R3 expected set");

    // R10 reset command with a stalled transmitter
    wr(3'd4, 3);
    repeat (3) @(negedge clk);
    chk("R10 stop and request held", {30'd0, tx_stop, sym_req_valid}, 3);
    chk("R10 nothing sent yet", 32'(n_rst), 0);
    sym_req_ready = 1;
    for (int k = 0; k < 20 && !out_err; k++) @(negedge clk);
    sym_req_ready = 0;
    chk("R10 four resets", 32'(n_rst), 4);
    chk("R10 request dropped", 32'(sym_req_valid), 0);
    repeat (2) @(negedge clk);
    chk("R10 still waiting", {30'd0, out_err, tx_stop}, 3);
    rd(3'd6, 4, "R10 status output-error");
    lresp_valid = 1; lresp_data = 16'h02A5;
    @(negedge clk);
    lresp_valid = 0; lresp_data = 0;
    @(negedge clk);
    chk("R10 released", {30'd0, out_err, tx_stop}, 0);
    rd(3'd5, 32'h2A5, "R12 response captured");
    rd(3'd4, 3, "R11 last command");

    // R11 input-status request
    sym_req_ready = 1;
    wr(3'd4, 4);
    repeat (3) @(negedge clk);
    sym_req_ready = 0;
    chk("R11 one status request", 32'(n_stat), 1);
    chk("R11 no other", 32'(n_other) + 32'(n_rst), 4);
    chk("R11 no stop", {30'd0, tx_stop, sym_req_valid}, 0);
    rd(3'd4, 4, "R11 last command status");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule